// File: doc/BRIEF.md
# Audio Receive Pair FIFO

This block stores left/right audio sample pairs that arrive from a serial receiver and hands them to a 32-bit bus reader. The FIFO has room for eight pairs, which is sixteen samples. Its occupancy is reported as a sample count, and a pair counts as two. Four read formats are available. Dual mode returns one sample per read, left first and then right. The two compact modes pack both channels of a pair into one read word, at 16 or 8 bits per channel. Mono mode returns the left sample and discards the whole pair.

The read side is controlled by a two-state machine. In state `PH_LEFT`, a read in dual mode returns the left sample and moves to `PH_RIGHT` (transition *left-taken*). The pair stays stored, so the level is odd while the machine is in `PH_RIGHT`. In `PH_RIGHT`, any read pops the pair and goes back to `PH_LEFT` (transition *pair-done*). In `PH_LEFT`, a read in a non-dual mode pops the pair and stays in `PH_LEFT` (transition *whole-pair*).

A programmable limit drives a service request, which is high while the level is above the limit. A pair that arrives while all eight slots are in use is dropped, and a sticky overrun flag is set.

Top module: `audio_rx_pairfifo`

## Requirements
- R1: After reset the level is 0, `svc_req` and `overrun` are 0, `rd_data` is 0 and `limit_rdata` reads 17. In all other cycles the level equals twice the number of stored pairs, minus 1 while a left sample has been taken in dual mode.
- R2: When `mode`=2'b00 (dual), the first read of a pair returns the left sample and lowers the level by 1. The next read returns the right sample and lowers the level by 1 again.
- R3: When `mode`=2'b01 (16-bit compact), a read returns the left sample's low 16 bits in bits [15:0] and the right sample's low 16 bits in bits [31:16]. The read removes the pair.
- R4: When `mode`=2'b10 (8-bit compact), a read returns the left sample's low byte in bits [7:0] and the right sample's low byte in bits [15:8]. Bits [31:16] are zero. The read removes the pair.
- R5: When `mode`=2'b11 (mono), a read returns the full left sample and removes the whole pair, so the level drops by 2.
- R6: `svc_req` is high exactly while the level is strictly greater than the stored limit. A limit of 0 requests whenever any sample is stored. A limit of 16 never requests.
- R7: `limit_rdata` returns bits [4:1] of the last written limit, and bit 0 always reads 1. The limit resets to 16.
- R8: A read while the FIFO is empty sets `rd_data` to 0 and leaves the level unchanged.
- R9: A pair offered while eight pairs are stored is discarded. The stored data is unchanged and `overrun` becomes 1 and stays 1 until reset.
- R10: Pairs are returned in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A received pair is presented this cycle |
| in_left | input | 32 | Left sample of the received pair |
| in_right | input | 32 | Right sample of the received pair |
| mode | input | 2 | Read format: 00 dual, 01 compact16, 10 compact8, 11 mono |
| rd_en | input | 1 | Bus read strobe; the result appears in `rd_data` after the edge |
| rd_data | output | 32 | Registered result of the latest read |
| limit_we | input | 1 | Write strobe for the request limit |
| limit_wdata | input | 5 | New limit value |
| limit_rdata | output | 5 | Limit read-back with bit 0 forced to 1 |
| level | output | 5 | Number of stored samples (0 to 16) |
| svc_req | output | 1 | Service request: level above limit |
| overrun | output | 1 | Sticky flag for a dropped pair |

## Verification
The assertions are checked on every cycle. They cover these points: the read machine never sits in `PH_RIGHT` with an empty store, a pop never happens on an empty store, the pair count stays within bounds, a read of an empty FIFO yields zero, a dropped pair leaves the count unchanged and sets the flag, the flag stays set, and the request stays low at limit 16 or at level 0. Some behaviours can only be shown by the bench comparing its scenarios against a reference queue. These are the exact packed layouts of each mode, left-before-right ordering, preserved arrival order, the odd level after a half-read pair, and the read-back value of the limit. Mode changes made partway through a pair are covered by the same comparison.

// File: rtl/audio_rxf_pkg.sv
package audio_rxf_pkg;
    typedef enum logic [1:0] {
        MODE_DUAL   = 2'b00,
        MODE_PACK16 = 2'b01,
        MODE_PACK8  = 2'b10,
        MODE_MONO   = 2'b11
    } chan_mode_e;

    typedef enum logic {
        PH_LEFT  = 1'b0,
        PH_RIGHT = 1'b1
    } phase_e;
endpackage

// File: rtl/rxf_pair_store.sv
module rxf_pair_store #(
    parameter int PAIR_DEPTH = 8,
    parameter int SAMPLE_W   = 32,
    localparam int PTR_W     = $clog2(PAIR_DEPTH),
    localparam int CNT_W     = $clog2(PAIR_DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                push,
    input  logic [SAMPLE_W-1:0] in_l,
    input  logic [SAMPLE_W-1:0] in_r,
    input  logic                pop,
    output logic [SAMPLE_W-1:0] head_l,
    output logic [SAMPLE_W-1:0] head_r,
    output logic [CNT_W-1:0]    count,
    output logic                empty,
    output logic                overrun
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(PAIR_DEPTH);

    logic [SAMPLE_W-1:0] mem_l [PAIR_DEPTH];
    logic [SAMPLE_W-1:0] mem_r [PAIR_DEPTH];
    logic [PTR_W-1:0]    wr_ptr, rd_ptr;
    logic                full, accept;

    assign full   = (count == FULL_CNT);
    assign empty  = (count == '0);
    assign accept = push && !full;
    assign head_l = mem_l[rd_ptr];
    assign head_r = mem_r[rd_ptr];

    always_ff @(posedge clk) begin
        if (accept) begin
            mem_l[wr_ptr] <= in_l;
            mem_r[wr_ptr] <= in_r;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count   <= '0;
            overrun <= 1'b0;
        end else begin
            if (accept) wr_ptr <= wr_ptr + 1'b1;
            if (pop)    rd_ptr <= rd_ptr + 1'b1;
            count <= count + CNT_W'(accept) - CNT_W'(pop);
            if (push && full) overrun <= 1'b1;
        end
    end

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> (count == FULL_CNT) && overrun);
    assert_sticky_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);
    assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT);
endmodule

// File: rtl/rxf_read_fsm.sv
module rxf_read_fsm
    import audio_rxf_pkg::*;
#(
    parameter int SAMPLE_W = 32,
    localparam int HALF_W  = SAMPLE_W / 2,
    localparam int QTR_W   = SAMPLE_W / 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rd_en,
    input  chan_mode_e          mode,
    input  logic                empty,
    input  logic [SAMPLE_W-1:0] head_l,
    input  logic [SAMPLE_W-1:0] head_r,
    output logic                pop,
    output logic                half,
    output logic [SAMPLE_W-1:0] rd_data
);
    phase_e              state_q, state_d;
    logic [SAMPLE_W-1:0] word;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PH_LEFT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        pop     = 1'b0;
        unique case (state_q)
            PH_LEFT: begin
                if (rd_en && !empty) begin
                    if (mode == MODE_DUAL) state_d = PH_RIGHT;  // left-taken
                    else                   pop     = 1'b1;      // whole-pair
                end
            end
            PH_RIGHT: begin
                if (rd_en) begin                                  // pair-done
                    pop     = 1'b1;
                    state_d = PH_LEFT;
                end
            end
        endcase
    end

    always_comb begin
        unique case (mode)
            MODE_DUAL:   word = (state_q == PH_RIGHT) ? head_r : head_l;
            MODE_PACK16: word = {head_r[HALF_W-1:0], head_l[HALF_W-1:0]};
            MODE_PACK8:  word = SAMPLE_W'({head_r[QTR_W-1:0], head_l[QTR_W-1:0]});
            MODE_MONO:   word = head_l;
        endcase
    end

    assign half = (state_q == PH_RIGHT);

    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= empty ? '0 : word;
    end

    assert_half_holds_pair_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_RIGHT) |-> !empty);
    assert_pop_nonempty_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
    assert_empty_read_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && empty) |=> (rd_data == '0));
endmodule

// File: rtl/rxf_request.sv
module rxf_request #(
    parameter int LVL_W   = 5,
    parameter int MAX_LVL = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             limit_we,
    input  logic [LVL_W-1:0] limit_wdata,
    input  logic [LVL_W-1:0] level,
    output logic [LVL_W-1:0] limit_rdata,
    output logic             svc_req
);
    logic [LVL_W-1:0] limit_q;

    always_ff @(posedge clk) begin
        if (!rst_n)        limit_q <= LVL_W'(MAX_LVL);
        else if (limit_we) limit_q <= limit_wdata;
    end

    assign limit_rdata = {limit_q[LVL_W-1:1], 1'b1};
    assign svc_req     = (level > limit_q);

    assert_quiet_at_max_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (limit_q == LVL_W'(MAX_LVL)) |-> !svc_req);
    assert_quiet_when_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (level == '0) |-> !svc_req);
endmodule

// File: rtl/audio_rx_pairfifo.sv
module audio_rx_pairfifo
    import audio_rxf_pkg::*;
#(
    parameter int PAIR_DEPTH = 8,
    parameter int SAMPLE_W   = 32,
    localparam int CNT_W     = $clog2(PAIR_DEPTH + 1),
    localparam int LVL_W     = $clog2(2 * PAIR_DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] in_left,
    input  logic [SAMPLE_W-1:0] in_right,
    input  logic [1:0]          mode,
    input  logic                rd_en,
    output logic [SAMPLE_W-1:0] rd_data,
    input  logic                limit_we,
    input  logic [LVL_W-1:0]    limit_wdata,
    output logic [LVL_W-1:0]    limit_rdata,
    output logic [LVL_W-1:0]    level,
    output logic                svc_req,
    output logic                overrun
);
    logic [SAMPLE_W-1:0] head_l, head_r;
    logic [CNT_W-1:0]    count;
    logic                empty, pop, half;

    rxf_pair_store #(.PAIR_DEPTH(PAIR_DEPTH), .SAMPLE_W(SAMPLE_W)) u_store (
        .clk(clk), .rst_n(rst_n), .push(in_valid), .in_l(in_left), .in_r(in_right),
        .pop(pop), .head_l(head_l), .head_r(head_r), .count(count),
        .empty(empty), .overrun(overrun)
    );

    rxf_read_fsm #(.SAMPLE_W(SAMPLE_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .mode(chan_mode_e'(mode)),
        .empty(empty), .head_l(head_l), .head_r(head_r),
        .pop(pop), .half(half), .rd_data(rd_data)
    );

    assign level = LVL_W'({count, 1'b0}) - LVL_W'(half);

    rxf_request #(.LVL_W(LVL_W), .MAX_LVL(2 * PAIR_DEPTH)) u_req (
        .clk(clk), .rst_n(rst_n), .limit_we(limit_we), .limit_wdata(limit_wdata),
        .level(level), .limit_rdata(limit_rdata), .svc_req(svc_req)
    );
endmodule

// File: tb/audio_rx_pairfifo_test.sv
module audio_rx_pairfifo_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_left = '0, in_right = '0;
    logic [1:0]  mode = 2'b00;
    logic        rd_en = 1'b0;
    logic [31:0] rd_data;
    logic        limit_we = 1'b0;
    logic [4:0]  limit_wdata = '0;
    logic [4:0]  limit_rdata, level;
    logic        svc_req, overrun;

    int checks = 0, errors = 0;
    logic [31:0] q_l[$], q_r[$];
    bit          m_half = 0, m_err = 0;
    int          m_limit = 16;
    logic [31:0] exp_rd = '0;
    string       rd_tag = "R1";

    always #10 clk = ~clk;

    audio_rx_pairfifo uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_left(in_left),
        .in_right(in_right), .mode(mode), .rd_en(rd_en), .rd_data(rd_data),
        .limit_we(limit_we), .limit_wdata(limit_wdata), .limit_rdata(limit_rdata),
        .level(level), .svc_req(svc_req), .overrun(overrun)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] pack(logic [1:0] m, bit h, logic [31:0] l, logic [31:0] r);
        case (m)
            2'b00:   return h ? r : l;
            2'b01:   return {r[15:0], l[15:0]};
            2'b10:   return {16'h0, r[7:0], l[7:0]};
            default: return l;
        endcase
    endfunction

    function automatic string mode_tag(logic [1:0] m);
        case (m)
            2'b00:   return "R2";
            2'b01:   return "R3";
            2'b10:   return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic step(bit push, logic [31:0] l, logic [31:0] r, bit rd, logic [1:0] m,
                        bit lwe, logic [4:0] lwd);
        bit full_pre;
        int exp_lvl;
        @(negedge clk);
        in_valid = push; in_left = l; in_right = r; rd_en = rd; mode = m;
        limit_we = lwe; limit_wdata = lwd;
        @(posedge clk);
        #1;
        in_valid = 0; rd_en = 0; limit_we = 0;
        full_pre = (q_l.size() == 8);
        if (lwe) m_limit = lwd;
        if (rd) begin
            if (q_l.size() == 0) begin
                exp_rd = '0; rd_tag = "R8";
            end else begin
                exp_rd = pack(m, m_half, q_l[0], q_r[0]);
                rd_tag = mode_tag(m);
                if (m == 2'b00 && !m_half) m_half = 1;
                else begin
                    void'(q_l.pop_front()); void'(q_r.pop_front()); m_half = 0;
                end
            end
        end
        if (push) begin
            if (full_pre) m_err = 1;
            else begin q_l.push_back(l); q_r.push_back(r); end
        end
        exp_lvl = 2 * q_l.size() - int'(m_half);
        chk({rd_tag, " R10 read data"}, rd_data, exp_rd);
        chk("R1 level", 32'(level), 32'(exp_lvl));
        chk("R6 svc_req", 32'(svc_req), 32'(exp_lvl > m_limit));
        chk("R9 overrun", 32'(overrun), 32'(m_err));
        chk("R7 limit readback", 32'(limit_rdata), 32'((m_limit & 30) | 1));
    endtask

    initial begin
        #(20ns * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset level", 32'(level), 0);
        chk("R1 reset svc", 32'(svc_req), 0);
        chk("R1 reset overrun", 32'(overrun), 0);
        chk("R1 reset rd_data", rd_data, 0);
        chk("R1 reset limit", 32'(limit_rdata), 17);
        @(negedge clk); rst_n = 1;

        // R7: even write reads back odd
        step(0, 0, 0, 0, 0, 1, 5'd4);
        chk("R7 limit 4 reads 5", 32'(limit_rdata), 5);
        // R8: empty read
        step(0, 0, 0, 1, 0, 0, 0);
        chk("R8 empty read zero", rd_data, 0);
        chk("R8 empty level", 32'(level), 0);
        // R2: dual left then right
        step(1, 32'h1111_AAAA, 32'h2222_BBBB, 0, 0, 0, 0);
        step(0, 0, 0, 1, 2'b00, 0, 0);
        chk("R2 left first", rd_data, 32'h1111_AAAA);
        chk("R2 odd level", 32'(level), 1);
        step(0, 0, 0, 1, 2'b00, 0, 0);
        chk("R2 right second", rd_data, 32'h2222_BBBB);
        // R3, R4, R5
        step(1, 32'hDEAD_1234, 32'hBEEF_5678, 0, 0, 0, 0);
        step(0, 0, 0, 1, 2'b01, 0, 0);
        chk("R3 compact16", rd_data, 32'h5678_1234);
        step(1, 32'h0000_12C3, 32'h0000_34D4, 0, 0, 0, 0);
        step(0, 0, 0, 1, 2'b10, 0, 0);
        chk("R4 compact8", rd_data, 32'h0000_D4C3);
        step(1, 32'hCAFE_F00D, 32'h0BAD_0001, 0, 0, 0, 0);
        chk("R5 level before", 32'(level), 2);
        step(0, 0, 0, 1, 2'b11, 0, 0);
        chk("R5 mono left", rd_data, 32'hCAFE_F00D);
        chk("R5 mono level", 32'(level), 0);
        // R9, R6, R10: fill past capacity
        for (int i = 0; i < 9; i++) step(1, 32'(100 + i), 32'(200 + i), 0, 0, 0, 0);
        chk("R9 full level", 32'(level), 16);
        chk("R9 overrun set", 32'(overrun), 1);
        step(0, 0, 0, 0, 0, 1, 5'd16);
        chk("R6 limit 16 silent", 32'(svc_req), 0);
        step(0, 0, 0, 0, 0, 1, 5'd0);
        chk("R6 limit 0 requests", 32'(svc_req), 1);
        for (int i = 0; i < 8; i++) begin
            step(0, 0, 0, 1, 2'b11, 0, 0);
            chk("R10 order", rd_data, 32'(100 + i));
        end
        chk("R6 drained quiet", 32'(svc_req), 0);

        // Random mix
        void'($urandom(32'd4242));
        for (int n = 0; n < 4000; n++) begin
            automatic bit p  = ($urandom % 100) < 45;
            automatic bit rd = ($urandom % 100) < 45;
            automatic bit lw = ($urandom % 100) < 5;
            step(p, $urandom, $urandom, rd, 2'($urandom % 4), lw, 5'(2 * ($urandom % 9)));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule